// File: doc/BRIEF.md
# Per-Channel Test Mode Controller

This block selects manufacturing test behaviour for a four-lane serial transceiver. One shared 4-bit test code bus feeds every lane. Each lane has its own load enable. While a lane's enable is high, that lane follows the bus. When the enable drops, the lane keeps the last code it took. The held code is decoded into lane controls:
- the source of the 10-bit receive word (recovered serial data or a filter accumulator);
- parallel loopback of the receive word onto the transmit word;
- a receive-path reset;
- a transmit-path reset;
- a forced-count mode, in which external pulses step the accumulator up or down.

Two controls are global and are not held per lane. The first is a bypass input, which cancels both held resets. The second is a single shared monitor pin. It is split into an input, an output and an output enable. When a lane asks for monitoring, the pin carries that lane's PLL feedback. Otherwise the pin acts as the decrement pulse input. The up and down pulse inputs are asynchronous. They are synchronized and edge-detected, so one pulse gives exactly one step. The hold element is a register with a clock enable, so a new code takes effect one clock after it is loaded.

Top module: `tmode_ctrl`

## Requirements
- R1: A lane's held code is replaced by `tcode` at each clock edge where its `ld_en` bit is high. While the bit is low, the held code stays unchanged whatever `tcode` does. The held code resets to 0000.
- R2: With every held code 0000 and `pll_bypass` low, every lane passes data through: `rx_out` equals `rx_ser`, `tx_out` equals `tx_in`, `rx_rst` and `tx_rst` are low, and `mon_oe` is low.
- R3: For held codes 0010, 0011, 0101 and 1000, the lane's `rx_out` shows its 10-bit accumulator. For all other codes it shows `rx_ser`.
- R4: For held codes 0110 and 0111, the lane's `tx_out` equals its `rx_ser` word, and `rx_out` still carries `rx_ser`. For all other codes, `tx_out` equals `tx_in`.
- R5: Held code 1000 asserts `rx_rst` and held code 1001 asserts `tx_rst`, each only while `pll_bypass` is low. A high `pll_bypass` keeps both low.
- R6: In held codes 0100 and 0101, each rising edge on `up_pulse` adds one to the lane's accumulator, and each rising edge on `mon_in` subtracts one.
- R7: The accumulator saturates: it never wraps below 0 or above 1023.
- R8: While `rx_rst` is high, the lane's accumulator is cleared to 0. Otherwise the accumulator keeps its value across code changes.
- R9: `mon_oe` is high exactly when some lane holds code 0001, 0011 or 0111. `mon_out` then carries the `pll_fb` bit of the lowest-numbered such lane, with lane 0 taking priority. Otherwise `mon_out` is 0.
- R10: Held codes 1010 through 1111 behave exactly as code 0000.
- R11: Rising edges on `mon_in` while `mon_oe` is high do not change any accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 4 | Per-lane load enable for the shared code |
| tcode | input | 4 | Shared local test code |
| pll_bypass | input | 1 | Global bypass; cancels held resets |
| up_pulse | input | 1 | Asynchronous increment pulse input |
| mon_in | input | 1 | Shared monitor pin, input side (decrement pulses) |
| mon_out | output | 1 | Shared monitor pin, output side |
| mon_oe | output | 1 | Shared monitor pin output enable |
| pll_fb | input | 4 | Per-lane PLL feedback bit to monitor |
| rx_ser | input | 40 | Recovered receive words, lane n at bits 10n+9:10n |
| tx_in | input | 40 | Core transmit words, same packing |
| rx_out | output | 40 | Receive words toward the core |
| tx_out | output | 40 | Transmit words toward the serializer |
| rx_rst | output | 4 | Per-lane receive reset |
| tx_rst | output | 4 | Per-lane transmit reset |

## Verification
The assertions assume that the pulse inputs stay high and low for at least two clocks each, so the synchronizer gives one edge per pulse. They also assume that `mon_in` is not pulsed while a code change could flip `mon_oe` partway through a pulse. The stimulus keeps within both limits. Each pulse is held for two clocks and followed by five idle clocks. Codes and the bypass level change only between pulses, never while one is being counted.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

   localparam int TM_CODE_W = 4;

   typedef struct packed {
      logic filt;
      logic lb;
      logic rx_hold;
      logic tx_hold;
      logic force_cnt;
      logic mon;
   } tmode_ctl_t;

   function automatic tmode_ctl_t tm_decode(input logic [TM_CODE_W-1:0] c);
      tmode_ctl_t d;
      d = '0;
      case (c)
         4'b0001: d.mon = 1'b1;
         4'b0010: d.filt = 1'b1;
         4'b0011: begin d.filt = 1'b1; d.mon = 1'b1; end
         4'b0100: d.force_cnt = 1'b1;
         4'b0101: begin d.filt = 1'b1; d.force_cnt = 1'b1; end
         4'b0110: d.lb = 1'b1;
         4'b0111: begin d.lb = 1'b1; d.mon = 1'b1; end
         4'b1000: begin d.filt = 1'b1; d.rx_hold = 1'b1; end
         4'b1001: d.tx_hold = 1'b1;
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/tmode_sync_edge.sv
module tmode_sync_edge #(
   parameter int STAGES      = 2,
   parameter bit RISING_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic evt
);
   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmode_sync_edge: STAGES must be at least 2");
   end

   logic [LAST:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= {q[LAST-1:0], din};
   end

   if (RISING_EDGE) begin : g_rise
      assign evt = q[LAST-1] & ~q[LAST];
   end else begin : g_fall
      assign evt = ~q[LAST-1] & q[LAST];
   end

   // R6
   evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt) else $error("edge event lasted more than one cycle");

endmodule

// File: rtl/tmode_chan.sv
module tmode_chan
   import tmode_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_en,
   input  logic [TM_CODE_W-1:0] tcode,
   input  logic                 bypass,
   input  logic                 up_evt,
   input  logic                 dn_evt,
   input  logic [WORD_W-1:0]    rx_ser,
   input  logic [WORD_W-1:0]    tx_in,
   output logic [WORD_W-1:0]    rx_out,
   output logic [WORD_W-1:0]    tx_out,
   output logic                 rx_rst,
   output logic                 tx_rst,
   output logic                 mon_req
);
   localparam logic [WORD_W-1:0] ACC_MAX = {WORD_W{1'b1}};
   localparam logic [WORD_W-1:0] ACC_ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   logic [TM_CODE_W-1:0] code_q;
   tmode_ctl_t           ctl;
   logic [WORD_W-1:0]    acc_q;
   logic                 clr;

   // hold element: clock-enabled register standing in for the gated latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code_q <= '0;
      else if (ld_en) code_q <= tcode;
   end

   assign ctl     = tm_decode(code_q);
   assign rx_rst  = ctl.rx_hold & ~bypass;
   assign tx_rst  = ctl.tx_hold & ~bypass;
   assign clr     = rx_rst;
   assign mon_req = ctl.mon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (ctl.force_cnt && (up_evt != dn_evt)) begin
         if (up_evt && acc_q != ACC_MAX)  acc_q <= acc_q + ACC_ONE;
         else if (dn_evt && acc_q != '0)  acc_q <= acc_q - ACC_ONE;
      end
   end

   assign rx_out = ctl.filt ? acc_q  : rx_ser;
   assign tx_out = ctl.lb   ? rx_ser : tx_in;

   // R1
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(code_q)) else $error("held code moved without load");
   // R1
   load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> code_q == $past(tcode)) else $error("held code missed load");
   // R5
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (!rx_rst && !tx_rst)) else $error("reset under bypass");
   // R4
   loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.lb |-> (tx_out == rx_ser && rx_out == rx_ser)) else $error("loopback word");
   // R6
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (acc_q == $past(acc_q) || acc_q == $past(acc_q) + ACC_ONE
                || acc_q == $past(acc_q) - ACC_ONE)) else $error("accumulator jump");
   // R6
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ctl.force_cnt) |=> $stable(acc_q)) else $error("count outside force mode");
   // R7
   sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q == ACC_MAX && !clr) |=> acc_q >= ACC_MAX - ACC_ONE) else $error("wrap at top");
   // R7
   sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q == '0) |=> acc_q <= ACC_ONE) else $error("wrap at zero");
   // R8
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> acc_q == '0) else $error("accumulator not cleared");

endmodule

// File: rtl/tmode_ctrl.sv
module tmode_ctrl
   import tmode_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int WORD_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        ld_en,
   input  logic [TM_CODE_W-1:0]     tcode,
   input  logic                     pll_bypass,
   input  logic                     up_pulse,
   input  logic                     mon_in,
   output logic                     mon_out,
   output logic                     mon_oe,
   input  logic [NUM_CH-1:0]        pll_fb,
   input  logic [NUM_CH*WORD_W-1:0] rx_ser,
   input  logic [NUM_CH*WORD_W-1:0] tx_in,
   output logic [NUM_CH*WORD_W-1:0] rx_out,
   output logic [NUM_CH*WORD_W-1:0] tx_out,
   output logic [NUM_CH-1:0]        rx_rst,
   output logic [NUM_CH-1:0]        tx_rst
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("tmode_ctrl: NUM_CH must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_w
      $error("tmode_ctrl: WORD_W must be at least 2");
   end

   logic              up_evt, dn_raw, dn_evt;
   logic [NUM_CH-1:0] mon_req;
   logic [NUM_CH-1:0] grant;

   tmode_sync_edge #(.STAGES(SYNC_STAGES), .RISING_EDGE(1'b1)) u_up (
      .clk(clk), .rst_n(rst_n), .din(up_pulse), .evt(up_evt));
   tmode_sync_edge #(.STAGES(SYNC_STAGES), .RISING_EDGE(1'b1)) u_dn (
      .clk(clk), .rst_n(rst_n), .din(mon_in), .evt(dn_raw));

   // decrement pulses only count while the shared pin is an input
   assign dn_evt = dn_raw & ~mon_oe;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      tmode_chan #(.WORD_W(WORD_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_en  (ld_en[ch]),
         .tcode  (tcode),
         .bypass (pll_bypass),
         .up_evt (up_evt),
         .dn_evt (dn_evt),
         .rx_ser (rx_ser[ch*WORD_W +: WORD_W]),
         .tx_in  (tx_in[ch*WORD_W +: WORD_W]),
         .rx_out (rx_out[ch*WORD_W +: WORD_W]),
         .tx_out (tx_out[ch*WORD_W +: WORD_W]),
         .rx_rst (rx_rst[ch]),
         .tx_rst (tx_rst[ch]),
         .mon_req(mon_req[ch])
      );
   end

   // lowest lane index wins the monitor pin
   always_comb begin
      grant = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mon_req[i]) grant = '0;
         if (mon_req[i]) grant[i] = 1'b1;
      end
   end

   assign mon_oe  = |mon_req;
   assign mon_out = |(grant & pll_fb);

   // R9
   grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant == '0) == !mon_oe)) else $error("monitor grant");
   // R9
   mon_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_oe |-> !mon_out) else $error("monitor driven while idle");
   // R11
   dn_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mon_oe |-> !dn_evt) else $error("decrement while pin driven");

endmodule

// File: tb/tmode_ctrl_test.sv
module tmode_ctrl_test;
   localparam int NC = 4;
   localparam int W  = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NC-1:0]   ld_en = '0;
   logic [3:0]      tcode = '0;
   logic            pll_bypass = 1'b0, up_pulse = 1'b0, mon_in = 1'b0;
   logic            mon_out, mon_oe;
   logic [NC-1:0]   pll_fb = '0;
   logic [NC*W-1:0] rx_ser = '0, tx_in = '0, rx_out, tx_out;
   logic [NC-1:0]   rx_rst, tx_rst;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [3:0]   m_code [NC];
   logic [W-1:0] m_acc  [NC];
   bit           m_byp;

   always #2 clk = ~clk;

   tmode_ctrl uut (.*);

   function automatic bit f_filt(logic [3:0] c); return c inside {4'd2, 4'd3, 4'd5, 4'd8}; endfunction
   function automatic bit f_lb  (logic [3:0] c); return c inside {4'd6, 4'd7}; endfunction
   function automatic bit f_mon (logic [3:0] c); return c inside {4'd1, 4'd3, 4'd7}; endfunction
   function automatic bit f_frc (logic [3:0] c); return c inside {4'd4, 4'd5}; endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply_clear();
      for (int c = 0; c < NC; c++) if (m_code[c] == 4'd8 && !m_byp) m_acc[c] = '0;
   endtask

   task automatic load(logic [NC-1:0] mask, logic [3:0] code);
      @(negedge clk); ld_en = mask; tcode = code;
      @(negedge clk); ld_en = '0; tcode = 4'($urandom);
      for (int c = 0; c < NC; c++) if (mask[c]) m_code[c] = code;
      @(negedge clk); apply_clear();
   endtask

   task automatic set_byp(bit b);
      @(negedge clk); pll_bypass = b; m_byp = b;
      repeat (2) @(negedge clk); apply_clear();
   endtask

   task automatic pulse(bit up);
      bit any_mon = 0;
      for (int c = 0; c < NC; c++) any_mon |= f_mon(m_code[c]);
      @(negedge clk); if (up) up_pulse = 1'b1; else mon_in = 1'b1;
      repeat (2) @(negedge clk); up_pulse = 1'b0; mon_in = 1'b0;
      repeat (5) @(negedge clk);
      for (int c = 0; c < NC; c++) if (f_frc(m_code[c])) begin
         if (up && m_acc[c] != {W{1'b1}}) m_acc[c]++;
         else if (!up && !any_mon && m_acc[c] != '0) m_acc[c]--;
      end
   endtask

   task automatic check_all(string ctx);
      int first = -1;
      @(negedge clk);
      rx_ser = {$urandom, $urandom}; tx_in = {$urandom, $urandom}; pll_fb = 4'($urandom);
      #1;
      for (int c = 0; c < NC; c++) begin
         logic [W-1:0] ser = rx_ser[c*W +: W];
         logic [W-1:0] e_rx = f_filt(m_code[c]) ? m_acc[c] : ser;
         logic [W-1:0] e_tx = f_lb(m_code[c]) ? ser : tx_in[c*W +: W];
         bit e_rr = (m_code[c] == 4'd8) && !m_byp;
         bit e_tr = (m_code[c] == 4'd9) && !m_byp;
         chk(rx_out[c*W +: W] == e_rx, {ctx, "/R3"}, $sformatf("rx_out lane %0d", c),
             int'(rx_out[c*W +: W]), int'(e_rx));
         chk(tx_out[c*W +: W] == e_tx, {ctx, "/R4"}, $sformatf("tx_out lane %0d", c),
             int'(tx_out[c*W +: W]), int'(e_tx));
         chk(rx_rst[c] == e_rr && tx_rst[c] == e_tr, {ctx, "/R5"},
             $sformatf("resets lane %0d", c), int'({rx_rst[c], tx_rst[c]}), int'({e_rr, e_tr}));
         if (first < 0 && f_mon(m_code[c])) first = c;
      end
      chk(mon_oe == (first >= 0), {ctx, "/R9"}, "mon_oe", int'(mon_oe), int'(first >= 0));
      chk(mon_out == ((first >= 0) ? pll_fb[first] : 1'b0), {ctx, "/R9"}, "mon_out",
          int'(mon_out), int'((first >= 0) ? pll_fb[first] : 1'b0));
   endtask

   initial begin
      void'($urandom(32'h5EED));
      for (int c = 0; c < NC; c++) begin m_code[c] = '0; m_acc[c] = '0; end
      m_byp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R2");
      load(4'b0001, 4'd6);                       // R1: later tcode changes ignored
      check_all("R1");
      load(4'b1111, 4'hC); check_all("R10");
      load(4'b1111, 4'hF); check_all("R10");
      load(4'b1111, 4'd0);
      load(4'b0001, 4'd4); load(4'b0010, 4'd5);  // R6
      repeat (3) pulse(1'b1);
      pulse(1'b0);
      load(4'b0001, 4'd2); check_all("R6");
      load(4'b0001, 4'd4); load(4'b0100, 4'd1);  // R11
      repeat (2) pulse(1'b0);
      load(4'b0001, 4'd2); check_all("R11");
      load(4'b0100, 4'd0);
      load(4'b0001, 4'd5);                       // R7
      repeat (4) pulse(1'b0);
      check_all("R7");
      repeat (1030) pulse(1'b1);
      check_all("R7");
      load(4'b0001, 4'd8); check_all("R8");
      set_byp(1'b1); load(4'b0010, 4'd9); check_all("R5");
      set_byp(1'b0); check_all("R5");
      for (int it = 0; it < 300; it++) begin
         case ($urandom % 5)
            0: load(4'($urandom), 4'($urandom));
            1: set_byp(~m_byp);
            2: pulse(1'b1);
            3: pulse(1'b0);
            default: ;
         endcase
         check_all("RND");
      end
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule